// File: doc/BRIEF.md
# Byte-Exchange SPI Master with Register Access

This peripheral runs one 8-bit full-duplex SPI exchange at a time. Software reaches it through a small synchronous register bus with four word addresses. The control word picks one of eight active-low chip selects, holds a select-enable bit and carries a completion flag. The mode word sets the bit-clock divisor, the clock polarity and the clock phase, and it also holds two stored transfer-format bits. Writing a byte to the transmit address starts an exchange. The block shifts that byte out MSB first on MOSI and shifts the slave's reply in from MISO. When the eighth bit has been captured, the block sets the completion flag.

The bit clock comes from the core clock through two counter stages. The first stage counts a linear factor. The second stage counts a power of two. Each exchange freezes the mode word when it starts, so software may reprogram the mode word while a byte is in flight. The chip select is driven only by the control word. It therefore stays asserted across any number of bytes until software clears the enable bit.

Top module: `byte_spi_host`

## Requirements
- R1: After reset, every register reads zero, all chip selects are high, and SCLK and MOSI are low. Word address 0 is control, 1 is mode, 2 is transmit (write-only, reads zero) and 3 is receive data (read-only).
- R2: Mode word layout: linear factor in bits [3:0]; exponent bit 0 in bit 4; exponent bits 2:1 in bits [6:5]; transfer-size bit 8; handshake bit 9; polarity bit 10; phase bit 11. These bits read back as written, and every other bit reads zero.
- R3: Control bit 0 enables the select, and bits [4:2] give the select number. While the enable bit is set, exactly chip select n is low, and it stays low across consecutive bytes. While it is clear, all chip selects are high.
- R4: One SCLK half period lasts max(linear factor, 1) × 2^exponent core cycles.
- R5: Control bit 1 is the completion flag. A control write with bit 1 at 0 clears the flag, and a write with bit 1 at 1 cannot set it. Hardware sets the flag when an exchange completes.
- R6: Each exchange produces exactly 16 SCLK transitions and moves bits MSB first. Between exchanges SCLK rests at the polarity bit.
- R7: With phase bit 0, data is launched on the leading SCLK edge and captured on the trailing edge. With phase bit 1, data is captured on the leading edge and launched on the trailing edge. The received byte reads back at address 3.
- R8: A transmit write made while an exchange is running is ignored.
- R9: A mode-word change made during an exchange takes effect only from the next exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| spi_sclk | output | 1 | Serial bit clock |
| spi_mosi | output | 1 | Serial data to slave |
| spi_miso | input | 1 | Serial data from slave |
| spi_cs_n | output | 8 | Active-low chip selects |

## Verification
A corrupted edge counter or shift register shows at the pins within one byte. The slave then receives a different byte, or the count of SCLK transitions between completions differs from 16. A prescaler that loads the live mode word instead of the frozen copy shows at the next SCLK transition as a wrong half-period length. A stuck or spuriously set completion flag shows at the next control read. A bad select decode shows one cycle after the control write, as a wrong pattern on the chip-select pins.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int LIN_W   = 4;
  localparam int EXP_W   = 3;
  localparam int FRAME_W = 8;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_TXD  = 2'd2;
  localparam logic [1:0] A_RXD  = 2'd3;

  localparam int C_ACT    = 0;
  localparam int C_RDY    = 1;
  localparam int C_SEL_LO = 2;

  localparam int M_LIN_LO = 0;
  localparam int M_EXP0   = 4;
  localparam int M_EXPHI  = 5;
  localparam int M_SIZE   = 8;
  localparam int M_HSK    = 9;
  localparam int M_CPOL   = 10;
  localparam int M_PHASE  = 11;

  typedef struct packed {
    logic [LIN_W-1:0] lin;
    logic [EXP_W-1:0] expo;
    logic             cpol;
    logic             cpha;  // 1: launch on leading edge
  } xfer_mode_t;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int LIN_W = 4,
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [LIN_W-1:0] lin,
  input  logic [EXP_W-1:0] expo,
  output logic             tick
);
  localparam int POW_W = (1 << EXP_W) - 1;

  logic [LIN_W-1:0] lin_cnt, lin_m1;
  logic [POW_W-1:0] pow_cnt, pow_max;

  // a zero linear factor behaves like one
  assign lin_m1  = (lin == '0) ? '0 : lin - LIN_W'(1);
  assign pow_max = (POW_W'(1) << expo) - POW_W'(1);
  assign tick    = run && (lin_cnt == lin_m1) && (pow_cnt == pow_max);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      lin_cnt <= '0;
      pow_cnt <= '0;
    end else if (lin_cnt == lin_m1) begin
      lin_cnt <= '0;
      pow_cnt <= (pow_cnt == pow_max) ? '0 : pow_cnt + POW_W'(1);
    end else begin
      lin_cnt <= lin_cnt + LIN_W'(1);
    end
  end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import spi_host_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [FW-1:0] tx_byte,
  input  xfer_mode_t    mode_live,
  input  logic          miso,
  output logic          sclk,
  output logic          mosi,
  output logic [FW-1:0] rx_byte,
  output logic          busy,
  output logic          done
);
  localparam int EDGES = 2 * FW;
  localparam int EW    = $clog2(EDGES);

  logic          busy_q, done_q, sclk_q, mosi_q, tick;
  xfer_mode_t    mode_q;
  logic [EW-1:0] edge_q;
  logic [FW-1:0] tx_q, rx_q;
  logic          capture_now;

  spi_rate_gen #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_rate (
    .clk  (clk),
    .rst  (rst),
    .run  (busy_q),
    .lin  (mode_q.lin),
    .expo (mode_q.expo),
    .tick (tick)
  );

  // even edge count = leading edge
  assign capture_now = (~edge_q[0]) ^ mode_q.cpha;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      mode_q <= '0;
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        sclk_q <= mode_live.cpol;
        if (start) begin
          busy_q <= 1'b1;
          mode_q <= mode_live;
          edge_q <= '0;
          rx_q   <= '0;
          if (!mode_live.cpha) begin
            mosi_q <= tx_byte[FW-1];
            tx_q   <= tx_byte << 1;
          end else begin
            tx_q   <= tx_byte;
          end
        end
      end else if (tick) begin
        sclk_q <= ~sclk_q;
        if (capture_now) begin
          rx_q <= {rx_q[FW-2:0], miso};
        end else begin
          mosi_q <= tx_q[FW-1];
          tx_q   <= tx_q << 1;
        end
        edge_q <= edge_q + EW'(1);
        if (edge_q == EW'(EDGES - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign rx_byte = rx_q;
  assign busy    = busy_q;
  assign done    = done_q;

  assert_sclk_home_R6: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (sclk_q == mode_q.cpol));
  assert_restart_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> $stable(mode_q));
  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && tick) |=> $stable(mode_q));
  assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(busy_q));
endmodule

// File: rtl/spi_sel_decode.sv
module spi_sel_decode #(
  parameter int NUM_CS = 8,
  parameter int SEL_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [SEL_W-1:0]  sel,
  output logic [NUM_CS-1:0] cs_n
);
  logic [NUM_CS-1:0] cs_n_q;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) cs_n_q[i] <= 1'b1;
      else     cs_n_q[i] <= !(active && (sel == SEL_W'(i)));
    end
  end

  assign cs_n = cs_n_q;

  assert_one_select_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n_q));
  assert_idle_release_R3: assert property (@(posedge clk) disable iff (rst)
    !active |=> (cs_n_q == '1));
endmodule

// File: rtl/byte_spi_host.sv
module byte_spi_host
  import spi_host_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 2,
  parameter int NUM_CS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam int SEL_W = $clog2(NUM_CS);
  localparam int USED  = M_PHASE + 1;

  logic             ctl_act, ctl_rdy;
  logic [SEL_W-1:0] ctl_sel;
  logic [LIN_W-1:0] mode_lin;
  logic [EXP_W-1:0] mode_exp;
  logic             mode_size, mode_hsk, mode_cpol, mode_phase;
  logic [BUS_W-1:0] rdata_q, rd_mux;
  logic             wr, rd, start;
  logic             eng_busy, eng_done;
  logic [FRAME_W-1:0] eng_rx;
  xfer_mode_t       mode_live;
  logic             wdata_unused;

  assign wr    = bus_valid && bus_write;
  assign rd    = bus_valid && !bus_write;
  assign start = wr && (bus_addr == ADDR_W'(A_TXD));
  assign wdata_unused = ^bus_wdata[BUS_W-1:USED];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_act    <= 1'b0;
      ctl_rdy    <= 1'b0;
      ctl_sel    <= '0;
      mode_lin   <= '0;
      mode_exp   <= '0;
      mode_size  <= 1'b0;
      mode_hsk   <= 1'b0;
      mode_cpol  <= 1'b0;
      mode_phase <= 1'b0;
    end else begin
      if (wr && bus_addr == ADDR_W'(A_CTRL)) begin
        ctl_act <= bus_wdata[C_ACT];
        ctl_sel <= bus_wdata[C_SEL_LO +: SEL_W];
      end
      if (eng_done)
        ctl_rdy <= 1'b1;
      else if (wr && bus_addr == ADDR_W'(A_CTRL))
        ctl_rdy <= ctl_rdy & bus_wdata[C_RDY];
      if (wr && bus_addr == ADDR_W'(A_MODE)) begin
        mode_lin   <= bus_wdata[M_LIN_LO +: LIN_W];
        mode_exp   <= {bus_wdata[M_EXPHI +: EXP_W-1], bus_wdata[M_EXP0]};
        mode_size  <= bus_wdata[M_SIZE];
        mode_hsk   <= bus_wdata[M_HSK];
        mode_cpol  <= bus_wdata[M_CPOL];
        mode_phase <= bus_wdata[M_PHASE];
      end
    end
  end

  always_comb begin
    mode_live.lin  = mode_lin;
    mode_live.expo = mode_exp;
    mode_live.cpol = mode_cpol;
    mode_live.cpha = ~mode_phase;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(A_CTRL): begin
        rd_mux[C_ACT]              = ctl_act;
        rd_mux[C_RDY]              = ctl_rdy;
        rd_mux[C_SEL_LO +: SEL_W]  = ctl_sel;
      end
      ADDR_W'(A_MODE): begin
        rd_mux[M_LIN_LO +: LIN_W]  = mode_lin;
        rd_mux[M_EXP0]             = mode_exp[0];
        rd_mux[M_EXPHI +: EXP_W-1] = mode_exp[EXP_W-1:1];
        rd_mux[M_SIZE]             = mode_size;
        rd_mux[M_HSK]              = mode_hsk;
        rd_mux[M_CPOL]             = mode_cpol;
        rd_mux[M_PHASE]            = mode_phase;
      end
      ADDR_W'(A_RXD): rd_mux[FRAME_W-1:0] = eng_rx;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
    else         rdata_q <= '0;
  end
  assign bus_rdata = rdata_q;

  spi_byte_engine #(.FW(FRAME_W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .tx_byte   (bus_wdata[FRAME_W-1:0]),
    .mode_live (mode_live),
    .miso      (spi_miso),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .rx_byte   (eng_rx),
    .busy      (eng_busy),
    .done      (eng_done)
  );

  spi_sel_decode #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_sel (
    .clk    (clk),
    .rst    (rst),
    .active (ctl_act),
    .sel    (ctl_sel),
    .cs_n   (spi_cs_n)
  );

  assert_ready_by_hw_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_rdy) |-> $past(eng_done));
  assert_busy_drops_on_done_R6: assert property (@(posedge clk) disable iff (rst)
    eng_done |-> !eng_busy);
endmodule

// File: tb/tb_byte_spi_host.sv
module tb_byte_spi_host;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [7:0]  spi_cs_n;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // bench view of the mode and slave model state
  logic       b_cpol = 0, b_cpha = 1;
  logic       armed = 0;
  logic [7:0] s_tx, s_rx;
  int         s_edges;
  logic [7:0] exp_q[$];

  // SCLK transition timing
  int cyc = 0, last_t = 0, last_half = 0, tog = 0;
  logic prev_sclk = 1'b0;

  byte_spi_host dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst && spi_sclk !== prev_sclk) begin
      tog++;
      last_half = cyc - last_t;
      last_t = cyc;
    end
    prev_sclk = spi_sclk;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // slave model and monitor: shifts on SCLK, compares what it received
  always @(spi_sclk) begin : slave_model
    logic lead;
    if (armed && !rst) begin
      lead = (spi_sclk !== b_cpol);
      if (lead ^ b_cpha) s_rx = {s_rx[6:0], spi_mosi};
      else begin spi_miso = s_tx[7]; s_tx = s_tx << 1; end
      s_edges++;
      if (s_edges == 16) begin
        armed = 0;
        if (exp_q.size() == 0) check("R8 unexpected exchange", {24'd0, s_rx}, 32'hx);
        else check("R6 R7 slave received byte", {24'd0, s_rx}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk); bus_valid = 0;
    d = bus_rdata;
  endtask

  task automatic set_mode(input int lin, input int ex, input logic cpol, input logic ph);
    logic [31:0] v;
    v = 32'(lin & 15) | (32'(ex & 1) << 4) | (32'((ex >> 1) & 3) << 5)
        | (32'(cpol) << 10) | (32'(ph) << 11);
    bus_wr(2'd1, v);
    b_cpol = cpol; b_cpha = ~ph;
  endtask

  task automatic xfer_start(input logic [7:0] mo, input logic [7:0] so, input int sel);
    bus_wr(2'd0, 32'((sel << 2) | 1));  // ready cleared, select on
    exp_q.push_back(mo);
    s_rx = 0; s_edges = 0;
    if (!b_cpha) begin spi_miso = so[7]; s_tx = so << 1; end
    else s_tx = so;
    armed = 1;
    bus_wr(2'd2, {24'd0, mo});
  endtask

  task automatic xfer_finish(input logic [7:0] so, input string tag);
    logic [31:0] d;
    bit got = 0;
    for (int i = 0; i < 5000 && !got; i++) begin
      bus_rd(2'd0, d);
      if (d[1]) got = 1;
    end
    check({tag, " R5 ready set by hardware"}, 32'(got), 32'd1);
    bus_rd(2'd3, d);
    check({tag, " R7 received byte"}, d, {24'd0, so});
    repeat (2) @(negedge clk);
    check({tag, " R6 SCLK rests at polarity"}, 32'(spi_sclk), 32'(b_cpol));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    int t0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);

    // R1 reset state
    check("R1 cs_n", {24'd0, spi_cs_n}, 32'hFF);
    check("R1 sclk", 32'(spi_sclk), 0);
    check("R1 mosi", 32'(spi_mosi), 0);
    bus_rd(2'd0, d); check("R1 control", d, 0);
    bus_rd(2'd1, d); check("R1 mode", d, 0);
    bus_rd(2'd3, d); check("R1 rx data", d, 0);

    // R5 software cannot set ready
    bus_wr(2'd0, 32'h2);
    bus_rd(2'd0, d); check("R5 write of 1 does not set ready", d, 0);

    // R2 layout and readback, upper/unused bits read zero
    bus_wr(2'd1, 32'h0000_0F65 | 32'hFFFF_F080);
    bus_rd(2'd1, d); check("R2 mode readback", d, 32'h0000_0F65);
    bus_wr(2'd1, 32'h0000_0315);
    bus_rd(2'd1, d); check("R2 mode readback 2", d, 32'h0000_0315);

    // R3 select decode
    bus_wr(2'd0, 32'(5 << 2) | 1); @(negedge clk);
    check("R3 select 5", {24'd0, spi_cs_n}, 32'hDF);
    bus_wr(2'd0, 32'(2 << 2)); @(negedge clk);
    check("R3 disabled", {24'd0, spi_cs_n}, 32'hFF);
    bus_wr(2'd0, 32'(7 << 2) | 1); @(negedge clk);
    check("R3 select 7", {24'd0, spi_cs_n}, 32'h7F);

    // R6 R7 all four polarity/phase combinations
    set_mode(1, 0, 0, 0); xfer_start(8'hA5, 8'h3C, 3); xfer_finish(8'h3C, "mode p0 ph0");
    set_mode(1, 0, 0, 1); xfer_start(8'h81, 8'h7E, 3); xfer_finish(8'h7E, "mode p0 ph1");
    set_mode(1, 0, 1, 0); xfer_start(8'h0F, 8'hC3, 3); xfer_finish(8'hC3, "mode p1 ph0");
    set_mode(1, 0, 1, 1); xfer_start(8'hF0, 8'h01, 3); xfer_finish(8'h01, "mode p1 ph1");
    check("R3 select held across bytes", {24'd0, spi_cs_n}, 32'hF7);

    // R4 divisor
    set_mode(3, 2, 0, 0); xfer_start(8'h55, 8'hAA, 3); xfer_finish(8'hAA, "div12");
    check("R4 half period 3x4", last_half, 12);
    set_mode(0, 1, 0, 0); xfer_start(8'h12, 8'h34, 3); xfer_finish(8'h34, "div2");
    check("R4 zero factor as one", last_half, 2);
    set_mode(15, 0, 1, 1); xfer_start(8'hFF, 8'h00, 3); xfer_finish(8'h00, "div15");
    check("R4 half period 15", last_half, 15);
    set_mode(2, 5, 0, 1); xfer_start(8'h6B, 8'h96, 3); xfer_finish(8'h96, "div64");
    check("R4 half period 2x32", last_half, 64);

    // R8 transmit write while busy ignored
    set_mode(2, 0, 0, 0);
    t0 = tog;
    xfer_start(8'hC9, 8'h5A, 1);
    bus_wr(2'd2, 32'h0000_0033);
    xfer_finish(8'h5A, "busy write");
    repeat (100) @(negedge clk);
    check("R8 only 16 SCLK transitions", tog - t0, 16);
    check("R8 no second exchange queued", exp_q.size(), 0);

    // R9 mode change mid-exchange
    set_mode(4, 0, 0, 0);
    xfer_start(8'h3E, 8'hE3, 6);
    repeat (10) @(negedge clk);
    set_mode(3, 2, 0, 0);
    xfer_finish(8'hE3, "mid change");
    check("R9 current byte keeps old divisor", last_half, 4);
    xfer_start(8'h77, 8'h88, 6); xfer_finish(8'h88, "after change");
    check("R9 next byte uses new divisor", last_half, 12);

    // R5 software clear, R3 release
    bus_wr(2'd0, 32'(6 << 2) | 1);
    bus_rd(2'd0, d); check("R5 ready cleared", 32'(d[1]), 0);
    bus_wr(2'd0, 32'h0); @(negedge clk);
    check("R3 release", {24'd0, spi_cs_n}, 32'hFF);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule